// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupt Detection

This block is a bank of general-purpose pins behind a small 32-bit register bus. Software sets the direction of each pin and its output value. Output bits can be written whole, or changed one bit at a time through a write-one-to-set alias and a write-one-to-clear alias, so no read-modify-write is needed. The input levels pass through a synchronizer and an optional per-pin debounce filter before software reads them.

Each pin can raise an interrupt. Three per-pin configuration vectors choose the detection mode:

- a kind vector picks level or edge detection;
- a polarity vector picks active-high or active-low, or rising or falling;
- a both-edges vector makes an edge-mode pin respond to either transition.

Edge events latch in a status register until software clears them with write-one-to-clear. Level-mode status follows the input. An enable vector gates detection, and a mask vector gates only the combined interrupt line. The pull-enable and pull-select settings are driven out for the pad ring and have no other effect.

The bus has no handshake. A write takes effect at the clock edge where `bus_wr` is high. Read data is a combinational function of `bus_addr`. There is no back-pressure: every access completes in its own cycle.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every register is zero, `pin_out`, `pin_oe`, `pull_en` and `pull_sel` are zero, and `irq` is low.
- R2: The output-value register (offset 0x00) drives `pin_out`, and the direction register (offset 0x08) drives `pin_oe`. A 1 in the direction register makes the pin an output. Both registers read back what was written.
- R3: Writing to offset 0x10 sets each output-value bit whose write bit is 1. Writing to offset 0x14 clears each output-value bit whose write bit is 1. Zero bits leave the output value unchanged.
- R4: With debounce off, offset 0x04 returns the pin level. A change on `pin_in` becomes readable after exactly two rising clock edges.
- R5: A pin with kind bit 0 (edge) and polarity bit 0 detects a rising edge. Its status bit (offset 0x24) reads 1 three clock edges after the input rises, and stays 1 after the input falls.
- R6: A pin with kind bit 0 and polarity bit 1 detects a falling edge only. A rising input leaves its status at 0.
- R7: A pin with kind bit 0 and both-edges bit 1 detects both rising and falling edges, whatever its polarity bit.
- R8: A pin with kind bit 1 (level) has a status that follows its active level. Polarity 0 means high is active; polarity 1 means low is active. A clear write does not lower the status while the level stays active.
- R9: Writing 1s to offset 0x30 clears the matching latched edge-mode status bits. When no edge is pending, `irq` then falls.
- R10: A pin whose enable bit (offset 0x20) is 0 never sets its status. A mask bit of 1 (offset 0x2C) keeps `irq` low for that pin but leaves its status visible. `irq` is the OR of all status bits that are enabled and unmasked.
- R11: When the debounce-enable bit (offset 0x40) is 1 and the prescale register (offset 0x44, 16 bits) is 0, a new level is accepted only after it has been stable for 3 prescaler ticks. A rising input is then readable after 5 clock edges, and a one-cycle glitch is never seen. The prescale register reads back its low 16 bits.
- R12: Offsets with no register read as zero, and writes to them change nothing. Writes to the read-only data-in and status offsets are ignored.
- R13: The pull-enable register (offset 0x18) and pull-select register (offset 0x1C) read back what was written and drive `pull_en` and `pull_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 7 | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pin_in | input | 32 | Raw pin levels from the pads |
| pin_out | output | 32 | Output value per pin |
| pin_oe | output | 32 | Output enable per pin (1 = output) |
| pull_en | output | 32 | Pull-resistor enable per pin |
| pull_sel | output | 32 | Pull direction select per pin |
| irq | output | 1 | Combined interrupt line |

## Verification
Register writes are visible on a read and on the pin outputs one edge after the strobe. A level change on a pin reaches the data-in read two edges later, and reaches the status bit and `irq` on the third edge. With debounce on and prescale 0, a level change is readable only on the fifth edge. The bench drives inputs and reads outputs on falling clock edges. For each result it checks both the cycle before it is due, where the old value must still hold, and the cycle it is due, so a change one cycle early or one cycle late is reported.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] REG_OUTVAL  = 7'h00;
  localparam logic [ADDR_W-1:0] REG_PINS    = 7'h04;
  localparam logic [ADDR_W-1:0] REG_DIR     = 7'h08;
  localparam logic [ADDR_W-1:0] REG_SETB    = 7'h10;
  localparam logic [ADDR_W-1:0] REG_CLRB    = 7'h14;
  localparam logic [ADDR_W-1:0] REG_PULLEN  = 7'h18;
  localparam logic [ADDR_W-1:0] REG_PULLSEL = 7'h1C;
  localparam logic [ADDR_W-1:0] REG_IEN     = 7'h20;
  localparam logic [ADDR_W-1:0] REG_ISTAT   = 7'h24;
  localparam logic [ADDR_W-1:0] REG_IMASK   = 7'h2C;
  localparam logic [ADDR_W-1:0] REG_ICLR    = 7'h30;
  localparam logic [ADDR_W-1:0] REG_IKIND   = 7'h34;
  localparam logic [ADDR_W-1:0] REG_IBOTH   = 7'h38;
  localparam logic [ADDR_W-1:0] REG_IPOL    = 7'h3C;
  localparam logic [ADDR_W-1:0] REG_DBEN    = 7'h40;
  localparam logic [ADDR_W-1:0] REG_DBDIV   = 7'h44;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_ctrl_pkg::*;
#(
  parameter int NPINS   = 32,
  parameter int PRESC_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  input  logic [NPINS-1:0]   pins_q,
  input  logic [NPINS-1:0]   status,
  output logic [NPINS-1:0]   dout,
  output logic [NPINS-1:0]   dir,
  output logic [NPINS-1:0]   pull_en,
  output logic [NPINS-1:0]   pull_sel,
  output logic [NPINS-1:0]   ien,
  output logic [NPINS-1:0]   imask,
  output logic [NPINS-1:0]   ikind,
  output logic [NPINS-1:0]   iboth,
  output logic [NPINS-1:0]   ipol,
  output logic [NPINS-1:0]   db_en,
  output logic [PRESC_W-1:0] db_div,
  output logic [NPINS-1:0]   iclr
);
  logic [NPINS-1:0] wbits;
  assign wbits = wdata[NPINS-1:0];

  // Clear request is a one-cycle pulse, never stored
  assign iclr = (wr && addr == REG_ICLR) ? wbits : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout <= '0; dir <= '0; pull_en <= '0; pull_sel <= '0;
      ien <= '0; imask <= '0; ikind <= '0; iboth <= '0; ipol <= '0;
      db_en <= '0; db_div <= '0;
    end else if (wr) begin
      case (addr)
        REG_OUTVAL:  dout     <= wbits;
        REG_SETB:    dout     <= dout | wbits;
        REG_CLRB:    dout     <= dout & ~wbits;
        REG_DIR:     dir      <= wbits;
        REG_PULLEN:  pull_en  <= wbits;
        REG_PULLSEL: pull_sel <= wbits;
        REG_IEN:     ien      <= wbits;
        REG_IMASK:   imask    <= wbits;
        REG_IKIND:   ikind    <= wbits;
        REG_IBOTH:   iboth    <= wbits;
        REG_IPOL:    ipol     <= wbits;
        REG_DBEN:    db_en    <= wbits;
        REG_DBDIV:   db_div   <= wdata[PRESC_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      REG_OUTVAL:  rdata[NPINS-1:0]   = dout;
      REG_PINS:    rdata[NPINS-1:0]   = pins_q;
      REG_DIR:     rdata[NPINS-1:0]   = dir;
      REG_PULLEN:  rdata[NPINS-1:0]   = pull_en;
      REG_PULLSEL: rdata[NPINS-1:0]   = pull_sel;
      REG_IEN:     rdata[NPINS-1:0]   = ien;
      REG_ISTAT:   rdata[NPINS-1:0]   = status;
      REG_IMASK:   rdata[NPINS-1:0]   = imask;
      REG_IKIND:   rdata[NPINS-1:0]   = ikind;
      REG_IBOTH:   rdata[NPINS-1:0]   = iboth;
      REG_IPOL:    rdata[NPINS-1:0]   = ipol;
      REG_DBEN:    rdata[NPINS-1:0]   = db_en;
      REG_DBDIV:   rdata[PRESC_W-1:0] = db_div;
      default:     rdata = '0;
    endcase
  end

  // R3
  set_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == REG_SETB) |=> ((dout & $past(wbits)) == $past(wbits)));

  // R3
  clr_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == REG_CLRB) |=> ((dout & $past(wbits)) == '0));
endmodule

// File: rtl/gpio_in_filter.sv
module gpio_in_filter #(
  parameter int NPINS       = 32,
  parameter int PRESC_W     = 16,
  parameter int DB_TICKS    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPINS-1:0]   pin_in,
  input  logic [NPINS-1:0]   db_en,
  input  logic [PRESC_W-1:0] db_div,
  output logic [NPINS-1:0]   filt
);
  localparam int CNT_W = $clog2(DB_TICKS + 1);

  logic [NPINS-1:0] sync_q [SYNC_STAGES];
  logic [NPINS-1:0] synced;
  logic [PRESC_W-1:0] pre_cnt;
  logic tick;
  logic [NPINS-1:0] held;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q[0] <= '0;
    else        sync_q[0] <= pin_in;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rst_n) sync_q[s] <= '0;
      else        sync_q[s] <= sync_q[s-1];
    end
  end

  assign synced = sync_q[SYNC_STAGES-1];

  // Shared prescaler: a tick every db_div+1 cycles
  assign tick = (pre_cnt == '0);
  always_ff @(posedge clk) begin
    if (!rst_n)    pre_cnt <= '0;
    else if (tick) pre_cnt <= db_div;
    else           pre_cnt <= pre_cnt - 1'b1;
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic [CNT_W-1:0] cnt;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        held[p] <= 1'b0;
        cnt     <= '0;
      end else if (!db_en[p]) begin
        held[p] <= synced[p];
        cnt     <= '0;
      end else if (synced[p] == held[p]) begin
        cnt <= '0;
      end else if (tick) begin
        if (cnt == CNT_W'(DB_TICKS - 1)) begin
          held[p] <= synced[p];
          cnt     <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
    assign filt[p] = db_en[p] ? held[p] : synced[p];
  end

  // R11
  db_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> (((held ^ $past(held)) & $past(db_en)) == '0));
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] filt,
  input  logic [NPINS-1:0] ien,
  input  logic [NPINS-1:0] ikind,
  input  logic [NPINS-1:0] iboth,
  input  logic [NPINS-1:0] ipol,
  input  logic [NPINS-1:0] iclr,
  output logic [NPINS-1:0] status
);
  logic [NPINS-1:0] prev;
  logic [NPINS-1:0] st_next;

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= '0;
    else        prev <= filt;
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_det
    logic rise, fall, hit, active;
    assign rise   = filt[p] & ~prev[p];
    assign fall   = ~filt[p] & prev[p];
    assign hit    = iboth[p] ? (rise | fall) : (ipol[p] ? fall : rise);
    assign active = filt[p] ^ ipol[p];
    always_comb begin
      if (ikind[p]) st_next[p] = ien[p] & active;
      else          st_next[p] = (status[p] & ~iclr[p]) | (ien[p] & hit);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) status <= '0;
    else        status <= st_next;
  end

  // R9
  edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(status & ~ikind & ~iclr) & status) == $past(status & ~ikind & ~iclr)));

  // R10
  gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(~ien & ~status) & status) == '0));
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_ctrl_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter int PRESC_W     = 16,
  parameter int DB_TICKS    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic [NPINS-1:0]  pull_en,
  output logic [NPINS-1:0]  pull_sel,
  output logic              irq
);
  logic [NPINS-1:0] filt, status, ien, imask, ikind, iboth, ipol, db_en, iclr;
  logic [PRESC_W-1:0] db_div;

  gpio_regs #(.NPINS(NPINS), .PRESC_W(PRESC_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
    .rdata(bus_rdata), .pins_q(filt), .status(status), .dout(pin_out),
    .dir(pin_oe), .pull_en(pull_en), .pull_sel(pull_sel), .ien(ien),
    .imask(imask), .ikind(ikind), .iboth(iboth), .ipol(ipol), .db_en(db_en),
    .db_div(db_div), .iclr(iclr)
  );

  gpio_in_filter #(.NPINS(NPINS), .PRESC_W(PRESC_W), .DB_TICKS(DB_TICKS),
                   .SYNC_STAGES(SYNC_STAGES)) u_filt (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .db_en(db_en),
    .db_div(db_div), .filt(filt)
  );

  gpio_irq_detect #(.NPINS(NPINS)) u_det (
    .clk(clk), .rst_n(rst_n), .filt(filt), .ien(ien), .ikind(ikind),
    .iboth(iboth), .ipol(ipol), .iclr(iclr), .status(status)
  );

  assign irq = |(status & ien & ~imask);

  // R10
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status != '0));
endmodule

// File: tb/sim_gpio_irq_ctrl.sv
module sim_gpio_irq_ctrl;
  localparam int CLK_P = 10;
  localparam int NV = 12;

  logic clk = 0, rst_n = 0, bus_wr = 0, irq;
  logic [6:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, pin_in = '0;
  logic [31:0] pin_out, pin_oe, pull_en, pull_sel;
  int checks = 0, errors = 0, cyc = 0;

  gpio_irq_ctrl u0 (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .pull_en(pull_en), .pull_sel(pull_sel), .irq(irq));

  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog got %0d exp < 20000 cycles", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // Table: write address/data, read address, expected read value
  localparam logic [6:0]  TW_A [NV] = '{7'h00, 7'h10, 7'h14, 7'h08, 7'h18, 7'h1C,
                                        7'h2C, 7'h28, 7'h24, 7'h44, 7'h04, 7'h4C};
  localparam logic [31:0] TW_D [NV] = '{32'h0000_00F0, 32'h0F00_0000, 32'h0000_0030,
    32'hFFFF_0000, 32'hA5A5_A5A5, 32'h0000_FFFF, 32'h1234_5678, 32'hFFFF_FFFF,
    32'hFFFF_FFFF, 32'h0001_0005, 32'hFFFF_FFFF, 32'h0000_0001};
  localparam logic [6:0]  TR_A [NV] = '{7'h00, 7'h00, 7'h00, 7'h08, 7'h18, 7'h1C,
                                        7'h2C, 7'h28, 7'h24, 7'h44, 7'h04, 7'h00};
  localparam logic [31:0] TR_E [NV] = '{32'h0000_00F0, 32'h0F00_00F0, 32'h0F00_00C0,
    32'hFFFF_0000, 32'hA5A5_A5A5, 32'h0000_FFFF, 32'h1234_5678, 32'h0,
    32'h0, 32'h0000_0005, 32'h0, 32'h0F00_00C0};
  // Requirement per row: R2 R3 R3 R2 R13 R13 R10 R12 R12 R11 R12 R12
  localparam int TREQ [NV] = '{2, 3, 3, 2, 13, 13, 10, 12, 12, 11, 12, 12};

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic step(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic cfg(input logic [31:0] en, kind, both, pol);
    wr(7'h34, kind); wr(7'h38, both); wr(7'h3C, pol);
    wr(7'h2C, 32'h0); wr(7'h20, en); wr(7'h30, 32'hFFFF_FFFF);
  endtask

  initial begin
    logic [31:0] v;
    step(3);
    rst_n = 1;
    step(1);
    // R1 reset state
    chk("R1 pin_out", pin_out, 32'h0);
    chk("R1 pin_oe", pin_oe, 32'h0);
    chk("R1 pulls", pull_en | pull_sel, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    rd(7'h24, v); chk("R1 status", v, 32'h0);

    for (int i = 0; i < NV; i++) begin
      wr(TW_A[i], TW_D[i]);
      rd(TR_A[i], v);
      if (v !== TR_E[i]) $display("  table row %0d (R%0d)", i, TREQ[i]);
      chk("table", v, TR_E[i]);
    end
    // R2 register values reach the pins
    chk("R2 pin_out", pin_out, 32'h0F00_00C0);
    chk("R2 pin_oe", pin_oe, 32'hFFFF_0000);
    // R13 pull settings exported
    chk("R13 pull_en", pull_en, 32'hA5A5_A5A5);
    chk("R13 pull_sel", pull_sel, 32'h0000_FFFF);
    wr(7'h44, 32'h0);

    // R4 two-edge synchronizer latency
    pin_in[0] = 1;
    step(1); rd(7'h04, v); chk("R4 early", v & 32'h1, 32'h0);
    step(1); rd(7'h04, v); chk("R4 due", v & 32'h1, 32'h1);

    // R5 rising edge on pin 1
    cfg(32'h2, 32'h0, 32'h0, 32'h0);
    pin_in[1] = 1;
    step(2); rd(7'h24, v); chk("R5 early", v & 32'h2, 32'h0);
    step(1); rd(7'h24, v); chk("R5 due", v & 32'h2, 32'h2);
    chk("R5 irq", {31'h0, irq}, 32'h1);
    pin_in[1] = 0;
    step(4); rd(7'h24, v); chk("R5 latched", v & 32'h2, 32'h2);
    // R9 write-one-to-clear
    wr(7'h30, 32'h2);
    rd(7'h24, v); chk("R9 cleared", v & 32'h2, 32'h0);
    chk("R9 irq low", {31'h0, irq}, 32'h0);

    // R6 falling only on pin 2
    cfg(32'h4, 32'h0, 32'h0, 32'h4);
    pin_in[2] = 1;
    step(4); rd(7'h24, v); chk("R6 rise ignored", v & 32'h4, 32'h0);
    pin_in[2] = 0;
    step(3); rd(7'h24, v); chk("R6 fall seen", v & 32'h4, 32'h4);

    // R7 both edges on pin 3, polarity 1 ignored
    cfg(32'h8, 32'h0, 32'h8, 32'h8);
    pin_in[3] = 1;
    step(3); rd(7'h24, v); chk("R7 rise", v & 32'h8, 32'h8);
    wr(7'h30, 32'h8);
    pin_in[3] = 0;
    step(3); rd(7'h24, v); chk("R7 fall", v & 32'h8, 32'h8);

    // R8 level high on pin 5
    cfg(32'h20, 32'h20, 32'h0, 32'h0);
    pin_in[5] = 1;
    step(3); rd(7'h24, v); chk("R8 level high", v & 32'h20, 32'h20);
    wr(7'h30, 32'h20);
    rd(7'h24, v); chk("R8 clear no effect", v & 32'h20, 32'h20);
    pin_in[5] = 0;
    step(3); rd(7'h24, v); chk("R8 level gone", v & 32'h20, 32'h0);
    // R8 active-low on pin 6
    pin_in[6] = 1; step(3);
    cfg(32'h40, 32'h40, 32'h0, 32'h40);
    rd(7'h24, v); chk("R8 low idle", v & 32'h40, 32'h0);
    pin_in[6] = 0;
    step(3); rd(7'h24, v); chk("R8 low active", v & 32'h40, 32'h40);

    // R10 disabled pin 7 never sets status
    cfg(32'h0, 32'h0, 32'h0, 32'h0);
    pin_in[7] = 1;
    step(4); rd(7'h24, v); chk("R10 disabled", v & 32'h80, 32'h0);
    // R10 mask hides irq but not status
    cfg(32'h2, 32'h0, 32'h0, 32'h0);
    wr(7'h2C, 32'h2);
    pin_in[1] = 1;
    step(3); rd(7'h24, v); chk("R10 masked status", v & 32'h2, 32'h2);
    chk("R10 masked irq", {31'h0, irq}, 32'h0);
    wr(7'h2C, 32'h0);
    chk("R10 unmasked irq", {31'h0, irq}, 32'h1);

    // R11 debounce on pin 4, prescale 0
    wr(7'h40, 32'h10);
    pin_in[4] = 1;
    step(4); rd(7'h04, v); chk("R11 early", v & 32'h10, 32'h0);
    step(1); rd(7'h04, v); chk("R11 due", v & 32'h10, 32'h10);
    pin_in[4] = 0; step(1); pin_in[4] = 1;
    step(6); rd(7'h04, v); chk("R11 glitch", v & 32'h10, 32'h10);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule